// File: doc/BRIEF.md
# UART Receive Buffer With Selectable Depth

This block is the receive-side character store of a UART-style peripheral. An upstream receiver hands it one 12-bit entry per accepted character. Bits 7:0 hold the data and bits 11:8 hold that character's error indications, with bit 10 meaning line break. The buffer keeps these entries in a circular store of `DEPTH` slots, which defaults to 16. Software drains it one entry per pop through the data-register read path.

A mode input chooses between two uses. In buffered mode the full depth is available. In single-slot mode only one entry may be held at a time. Any change of the mode input flushes the buffer. The block drives a ready output that tells the upstream receiver whether a push will be taken. It also drives empty and full flags inside a status byte, and a level receive interrupt request. That request sets when a push brings the entry count up to the trigger level. It clears when a pop brings the count down to one below that level.

Top module: `rxq_buffer`

## Requirements
- R1: After reset the status byte `flags_o` reads 0x90, `rx_irq_o` is 0 and `rx_ready_o` is 1. In the status byte, bit 7 is transmit-empty and is fixed at 1, bit 6 is receive-full, bit 5 is transmit-full and is fixed at 0, and bit 4 is receive-empty. The other bits are 0.
- R2: In buffered mode (`fifo_en_i`=1) entries pop out in push order. `rx_ready_o` is 1 while fewer than `DEPTH` entries are held.
- R3: In single-slot mode (`fifo_en_i`=0) `rx_ready_o` is 1 only while the buffer holds no entry, so at most one entry is held.
- R4: A push offered while `rx_ready_o` is 0 is discarded. The held entries and their order do not change.
- R5: Status bit 6 (full) sets on a push that brings the count to `DEPTH` in buffered mode, or on any accepted push in single-slot mode. A pop clears it.
- R6: Status bit 4 (empty) is 1 exactly when the count is 0. An accepted push clears it.
- R7: A pop while empty changes no state. `pop_data_o` always shows the entry at the read position, so the next pushed entry is the next one popped.
- R8: With trigger level `TRIG_LEVEL` (default 1), `rx_irq_o` sets one cycle after an accepted push, with no pop, brings the count to the trigger level. It clears one cycle after a pop, with no accepted push, brings the count to the trigger level minus 1. Otherwise it holds.
- R9: `brk_i` pushes the entry 0x400, which is bit 10 set and data zero, whatever `push_data_i` carries in the same cycle.
- R10: In a cycle where `fifo_en_i` differs from the mode in use, `rx_ready_o` is 0 and pushes and pops are ignored. On the next cycle the buffer is empty, not full, the interrupt is low and the new mode applies.
- R11: An accepted push together with a pop of a non-empty buffer leaves the count, the flags and the interrupt unchanged. The popped entry is the oldest one.
- R12: Slots are written at the read position plus the count, modulo `DEPTH`, so the order holds across any number of wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 = buffered mode, 0 = single-slot mode |
| push_i | input | 1 | Push `push_data_i` |
| push_data_i | input | ENTRY_W | Received entry: data plus error bits |
| brk_i | input | 1 | Push a line-break entry |
| pop_i | input | 1 | Pop the oldest entry (data-register read) |
| pop_data_o | output | ENTRY_W | Entry at the read position |
| rx_ready_o | output | 1 | A push in this cycle will be accepted |
| flags_o | output | 8 | Status byte (see R1) |
| rx_irq_o | output | 1 | Receive interrupt request |

## Verification
All state is registered on the rising edge. `rx_ready_o` and `pop_data_o` are combinational from that state and from `fifo_en_i`. The bench drives a stimulus at a falling edge and checks the pre-edge values of `rx_ready_o` and `pop_data_o` before the rising edge. It checks flags, interrupt, readiness and head entry at the following falling edge, one cycle after the stimulus. Mode changes are checked twice: during the change cycle for a ready of 0, and one cycle later for the flushed state. A queue model advanced at each rising edge supplies every expected value.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;
  localparam int unsigned ENTRY_W = 12;
  localparam int unsigned BRK_BIT = 10;
  localparam logic [ENTRY_W-1:0] BRK_ENTRY = ENTRY_W'(1) << BRK_BIT;
  // status byte bit positions
  localparam int unsigned FLG_TXE = 7;
  localparam int unsigned FLG_RXF = 6;
  localparam int unsigned FLG_TXF = 5;
  localparam int unsigned FLG_RXE = 4;
endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned ENTRY_W = 12,
  localparam int unsigned PTR_W  = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [PTR_W-1:0]   waddr_i,
  input  logic [ENTRY_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]   raddr_i,
  output logic [ENTRY_W-1:0] rdata_o
);
  logic [ENTRY_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= '0;
      else if (we_i && waddr_i == PTR_W'(g))        mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rxq_ctrl.sv
`timescale 1ns/1ps
module rxq_ctrl #(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned TRIG_LEVEL = 1,
  localparam int unsigned PTR_W     = $clog2(DEPTH),
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1),
  localparam int unsigned SUM_W     = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             we_o,
  output logic [PTR_W-1:0] waddr_o,
  output logic [PTR_W-1:0] raddr_o,
  output logic             ready_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             irq_o
);
  logic [PTR_W-1:0] rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mode_q, full_q, full_d, empty_q, irq_q, irq_d;
  logic             toggle, push_acc, pop_eff, pop_clr;
  logic [SUM_W-1:0] slot_sum;

  assign toggle   = fifo_en_i ^ mode_q;
  assign ready_o  = !toggle && (mode_q ? (cnt_q < CNT_W'(DEPTH)) : (cnt_q == '0));
  assign push_acc = push_i && ready_o;
  assign pop_clr  = pop_i && !toggle;
  assign pop_eff  = pop_clr && (cnt_q != '0);

  // write slot = read position + count, modulo DEPTH
  assign slot_sum = SUM_W'(rd_q) + SUM_W'(cnt_q);
  assign waddr_o  = PTR_W'((slot_sum >= SUM_W'(DEPTH)) ? slot_sum - SUM_W'(DEPTH) : slot_sum);
  assign we_o     = push_acc;
  assign raddr_o  = rd_q;

  always_comb begin
    rd_d = rd_q;
    if (pop_eff) rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    cnt_d = cnt_q;
    if (push_acc && !pop_eff)      cnt_d = cnt_q + 1'b1;
    else if (!push_acc && pop_eff) cnt_d = cnt_q - 1'b1;
    full_d = full_q;
    if (push_acc)     full_d = mode_q ? (cnt_d == CNT_W'(DEPTH)) : 1'b1;
    else if (pop_clr) full_d = 1'b0;
    irq_d = irq_q;
    if (push_acc && !pop_eff && cnt_d == CNT_W'(TRIG_LEVEL))          irq_d = 1'b1;
    else if (pop_clr && !push_acc && cnt_d == CNT_W'(TRIG_LEVEL - 1)) irq_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0; cnt_q <= '0; mode_q <= 1'b0;
      full_q <= 1'b0; empty_q <= 1'b1; irq_q <= 1'b0;
    end else if (toggle) begin
      rd_q <= '0; cnt_q <= '0; mode_q <= fifo_en_i;
      full_q <= 1'b0; empty_q <= 1'b1; irq_q <= 1'b0;
    end else begin
      rd_q <= rd_d; cnt_q <= cnt_d;
      full_q <= full_d; empty_q <= (cnt_d == '0); irq_q <= irq_d;
    end
  end

  assign full_o  = full_q;
  assign empty_o = empty_q;
  assign irq_o   = irq_q;

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  // R3
  single_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |-> cnt_q <= CNT_W'(1));
  // R6
  push_clears_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && ready_o) |=> !empty_o);
  // R7
  empty_pop_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !toggle && cnt_q == '0) |=> ($stable(rd_q) && cnt_q == '0));
  // R8
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && ready_o && !pop_i && cnt_q == CNT_W'(TRIG_LEVEL - 1)) |=> irq_o);
  // R10
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle |=> (cnt_q == '0 && rd_q == '0 && !irq_o && !full_o));
  // R11
  push_pop_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && ready_o && pop_i && cnt_q != '0) |=> $stable(cnt_q));
endmodule

// File: rtl/rxq_buffer.sv
`timescale 1ns/1ps
module rxq_buffer #(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned TRIG_LEVEL = 1,
  parameter int unsigned ENTRY_W    = rxq_pkg::ENTRY_W,
  localparam int unsigned PTR_W     = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fifo_en_i,
  input  logic               push_i,
  input  logic [ENTRY_W-1:0] push_data_i,
  input  logic               brk_i,
  input  logic               pop_i,
  output logic [ENTRY_W-1:0] pop_data_o,
  output logic               rx_ready_o,
  output logic [7:0]         flags_o,
  output logic               rx_irq_o
);
  import rxq_pkg::*;

  logic               we, full, empty;
  logic [PTR_W-1:0]   waddr, raddr;
  logic [ENTRY_W-1:0] wdata;

  assign wdata = brk_i ? ENTRY_W'(BRK_ENTRY) : push_data_i;

  rxq_ctrl #(.DEPTH(DEPTH), .TRIG_LEVEL(TRIG_LEVEL)) u_ctrl (
    .clk_i, .rst_ni, .fifo_en_i,
    .push_i  (push_i | brk_i),
    .pop_i,
    .we_o    (we),
    .waddr_o (waddr),
    .raddr_o (raddr),
    .ready_o (rx_ready_o),
    .full_o  (full),
    .empty_o (empty),
    .irq_o   (rx_irq_o)
  );

  rxq_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
    .clk_i, .rst_ni,
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (pop_data_o)
  );

  always_comb begin
    flags_o          = '0;
    flags_o[FLG_TXE] = 1'b1;  // no transmit path here
    flags_o[FLG_TXF] = 1'b0;
    flags_o[FLG_RXF] = full;
    flags_o[FLG_RXE] = empty;
  end

  // R9
  brk_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_i && we) |-> (wdata[BRK_BIT] && wdata[7:0] == 8'h00));
  // R1
  tx_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[FLG_TXE] && !flags_o[FLG_TXF]);
endmodule

// File: tb/rxq_buffer_bench.sv
`timescale 1ns/1ps
module rxq_buffer_bench;
  localparam int DEPTH = 16;
  localparam int TRIG  = 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, fifo_en, push, brk, pop, ready, irq;
  logic [11:0] push_data, pop_data;
  logic [7:0]  flags;

  rxq_buffer u_rxq_buffer (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .push_i(push),
    .push_data_i(push_data), .brk_i(brk), .pop_i(pop), .pop_data_o(pop_data),
    .rx_ready_o(ready), .flags_o(flags), .rx_irq_o(irq)
  );

  logic [11:0] mq[$];
  bit m_fifo, m_full, m_irq;
  int n_chk = 0, n_fail = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_ready();
    return m_fifo ? (mq.size() < DEPTH) : (mq.size() == 0);
  endfunction

  task automatic check_outs(string req);
    check({req, " flags"}, 32'(flags),
          32'({1'b1, m_full, 1'b0, mq.size() == 0, 4'b0000}));
    check({req, " irq"}, 32'(irq), 32'(m_irq));
    check({req, " ready"}, 32'(ready), 32'(m_ready()));
    if (mq.size() > 0) check({req, " head"}, 32'(pop_data), 32'(mq[0]));
  endtask

  // called at a falling edge; checks one cycle after the stimulus
  task automatic cycle(string req, bit p, logic [11:0] d, bit b, bit q);
    bit acc, peff;
    logic [11:0] ent;
    push = p; push_data = d; brk = b; pop = q;
    acc  = (p || b) && m_ready();
    peff = q && mq.size() > 0;
    ent  = b ? 12'h400 : d;
    #1;
    check({req, " ready pre"}, 32'(ready), 32'(m_ready()));
    if (peff) check({req, " pop data"}, 32'(pop_data), 32'(mq[0]));
    @(posedge clk);
    if (peff) void'(mq.pop_front());
    if (acc) mq.push_back(ent);
    if (acc) m_full = m_fifo ? (mq.size() == DEPTH) : 1'b1;
    else if (q) m_full = 1'b0;
    if (acc && !peff && mq.size() == TRIG) m_irq = 1'b1;
    else if (q && !acc && mq.size() == TRIG - 1) m_irq = 1'b0;
    @(negedge clk);
    push = 0; brk = 0; pop = 0;
    check_outs(req);
  endtask

  task automatic set_mode(bit en);
    fifo_en = en; push = 1; push_data = 12'h0aa; pop = 1;
    #1;
    check("R10 ready during change", 32'(ready), 32'd0);
    @(posedge clk);
    mq.delete(); m_full = 0; m_irq = 0; m_fifo = en;
    @(negedge clk);
    push = 0; pop = 0;
    check_outs("R10 flushed");
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; fifo_en = 0; push = 0; brk = 0; pop = 0; push_data = '0;
    m_fifo = 0; m_full = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 flags reset", 32'(flags), 32'h90);
    check_outs("R1");

    // single-slot mode
    cycle("R3 push", 1, 12'h141, 0, 0);
    cycle("R4 dropped push", 1, 12'h0ff, 0, 0);
    cycle("R3 pop", 0, 12'h000, 0, 1);
    cycle("R7 pop empty", 0, 12'h000, 0, 1);
    cycle("R7 push after empty pop", 1, 12'h255, 0, 0);
    cycle("R11 single push+pop", 1, 12'h077, 0, 1);
    cycle("R9 break", 0, 12'h000, 1, 0);
    cycle("R9 pop", 0, 12'h000, 0, 1);
    cycle("R9 break beats data", 1, 12'h3ff, 1, 0);
    cycle("R9 pop", 0, 12'h000, 0, 1);
    cycle("R11 push+pop empty", 1, 12'h0c3, 0, 1);

    set_mode(1);

    // fill sweep over every count, then drain past empty
    for (int n = 0; n <= DEPTH + 1; n++) begin
      for (int i = 0; i < n; i++)
        cycle("R2 R5 R8 fill", 1, 12'((n << 7) ^ i ^ 12'h800), 0, 0);
      for (int i = 0; i <= n; i++)
        cycle("R2 R6 R8 drain", 0, 12'h000, 0, 1);
    end

    // wrap with simultaneous push and pop
    for (int i = 0; i < 5; i++) cycle("R12 prefill", 1, 12'(12'h100 + i), 0, 0);
    for (int k = 0; k < 40; k++) cycle("R11 R12 stream", 1, 12'(12'h200 + k), 0, 1);
    for (int i = 0; i < 6; i++) cycle("R12 drain", 0, 12'h000, 0, 1);

    // full, dropped push, then flush by mode change
    for (int i = 0; i < DEPTH; i++) cycle("R5 fill", 1, 12'(12'h300 + i), 0, 0);
    cycle("R4 push when full", 1, 12'h7ee, 0, 0);
    cycle("R5 pop clears full", 0, 12'h000, 0, 1);
    cycle("R2 refill", 1, 12'h3aa, 0, 0);
    set_mode(0);
    cycle("R7 pop after flush", 0, 12'h000, 0, 1);
    cycle("R3 push after flush", 1, 12'h123, 0, 0);
    cycle("R3 pop", 0, 12'h000, 0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule